// File: doc/BRIEF.md
# Radix-4 Constant-Twiddle Dragonfly Node

This block is a single radix-4 decimation-in-frequency node for a fully parallel transform. Four complex fixed-point samples, called a, b, c and d, arrive together in one cycle under an input valid strobe. An add/subtract network forms the four radix-4 branch sums. The quarter-turn rotations inside the node are done by swapping and negating real and imaginary parts. Branch 0 leaves as a plain sum. Branches 1, 2 and 3 are each multiplied by a twiddle factor that is fixed when the node is elaborated.

Every twiddle multiply is built from shifted copies of the operand, one copy for each set bit in the constant's magnitude. The sign is applied separately, so no hardware multiplier is used. A branch whose twiddle angle works out to zero gets a plain delay register in place of the multiplier. All four outputs leave together, a fixed two cycles after the input. The valid strobe travels with the data.

A transform built from these nodes sets the node index parameter K for each node. Branch m then uses the twiddle exponent m·K modulo the transform size.

Top module: `dragonfly_r4_const`

## Requirements
- R1: Output branch 0 equals the exact sum a+b+c+d, real and imaginary parts separately, sign-extended to the output width with no rounding.
- R2: Output branch 1 equals (a − j·b − c + j·d) multiplied by W^(K mod NPTS), rescaled as in R6.
- R3: Output branch 2 equals (a − b + c − d) multiplied by W^(2K mod NPTS), rescaled as in R6.
- R4: Output branch 3 equals (a + j·b − c − j·d) multiplied by W^(3K mod NPTS), rescaled as in R6.
- R5: The twiddle W^n is Cn − j·Sn. Cn = round(2^TW·cos(2πn/NPTS)) and Sn = round(2^TW·sin(2πn/NPTS)), where round means nearest integer with halves away from zero.
- R6: A rotated result v (real or imaginary product sum) is output as floor((v + 2^(TW−1)) / 2^TW), that is, round half up.
- R7: A branch whose exponent m·K mod NPTS is zero passes its sum through a register with the same two-cycle latency. For example, with K = 128, branch 2 passes through unchanged.
- R8: out_valid is in_valid delayed by exactly two clock cycles, and each output sample belongs to the input accepted two cycles earlier.
- R9: Inputs presented while in_valid is low are ignored, and every output holds its last value.
- R10: While rst_n is low at a clock edge, all outputs and out_valid are cleared to zero, whatever in_valid and the data inputs are doing.
- R11: Outputs are DW+3 bits signed. Extreme inputs, such as every part at the most negative or most positive DW-bit value, give correct results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The four input samples are valid this cycle |
| a_re | input | DW | Sample a, real part, signed |
| a_im | input | DW | Sample a, imaginary part, signed |
| b_re | input | DW | Sample b, real part, signed |
| b_im | input | DW | Sample b, imaginary part, signed |
| c_re | input | DW | Sample c, real part, signed |
| c_im | input | DW | Sample c, imaginary part, signed |
| d_re | input | DW | Sample d, real part, signed |
| d_im | input | DW | Sample d, imaginary part, signed |
| out_valid | output | 1 | Output branches carry a new result |
| y0_re | output | DW+3 | Branch 0 real part, signed |
| y0_im | output | DW+3 | Branch 0 imaginary part, signed |
| y1_re | output | DW+3 | Branch 1 real part, signed |
| y1_im | output | DW+3 | Branch 1 imaginary part, signed |
| y2_re | output | DW+3 | Branch 2 real part, signed |
| y2_im | output | DW+3 | Branch 2 imaginary part, signed |
| y3_re | output | DW+3 | Branch 3 real part, signed |
| y3_im | output | DW+3 | Branch 3 imaginary part, signed |

## Verification
In a single node instance, a zero-angle delay branch and true shift-add rotated branches produce results in the same cycle, and they must stay aligned. This is provoked by running two instances side by side on the same stimulus: one with K = 13, where every branch except branch 0 is rotated, and one with K = 128, where branch 2 folds to a delay and branches 1 and 3 wrap to a half turn. Random bursts with idle gaps mixed in are applied, and each branch of both instances is compared in every cycle against a reference computed in floating point, which judges alignment, rounding and holding together.

// File: rtl/dfly_pkg.sv
// Shared constants and elaboration-time twiddle arithmetic for the dragonfly node.
// Assumes: twiddle exponents are non-negative; trig values are evaluated with a
// series expansion on an angle wrapped into [-pi, pi] so no math library is needed.
package dfly_pkg;

    localparam int  BRANCHES = 4;
    localparam real TWO_PI   = 6.283185307179586;

    // Exponent used by branch m of a node with index k in an npts-point transform.
    function automatic int twiddle_index(input int m, input int k, input int npts);
        return (m * k) % npts;
    endfunction

    // Angle 2*pi*n/npts, wrapped into [-pi, pi] to keep the series accurate.
    function automatic real wrapped_angle(input int n, input int npts);
        int w;
        w = n % npts;
        if (w > npts / 2) w = w - npts;
        return TWO_PI * real'(w) / real'(npts);
    endfunction

    // Power series for sine (want_sin=1) or cosine (want_sin=0).
    function automatic real series_trig(input real x, input bit want_sin);
        real term;
        real acc;
        term = want_sin ? x : 1.0;
        acc  = term;
        for (int i = 1; i < 24; i++) begin
            if (want_sin) term = -term * x * x / real'((2 * i) * (2 * i + 1));
            else          term = -term * x * x / real'((2 * i - 1) * (2 * i));
            acc = acc + term;
        end
        return acc;
    endfunction

    // Scaled cosine of the twiddle, rounded to nearest (halves away from zero).
    function automatic int twiddle_cos_q(input int n, input int npts, input int frac);
        return int'(series_trig(wrapped_angle(n, npts), 1'b0) * real'(1 << frac));
    endfunction

    // Scaled sine of the twiddle; the twiddle itself is cos - j*sin.
    function automatic int twiddle_sin_q(input int n, input int npts, input int frac);
        return int'(series_trig(wrapped_angle(n, npts), 1'b1) * real'(1 << frac));
    endfunction

endpackage

// File: rtl/dfly_cmul.sv
// Shift-add multiplier by a signed elaboration-time constant.
// Works on magnitudes: the operand's absolute value is summed once per set bit of
// |COEF|, then the product sign is restored. Purely combinational.
// Assumes: |COEF| < 2**(TW+1) and PW >= IW+TW+2.
module dfly_cmul #(
    parameter int IW   = 7,
    parameter int TW   = 10,
    parameter int COEF = 1024,
    parameter int PW   = IW + TW + 2
) (
    input  logic signed [IW-1:0] op,
    output logic signed [PW-1:0] prod
);
    localparam int MAG = (COEF < 0) ? -COEF : COEF;
    localparam bit NEG = (COEF < 0);
    localparam int MB  = TW + 1;

    logic signed [PW-1:0] op_ext;
    logic        [PW-1:0] op_mag;
    logic        [PW-1:0] term [MB];
    logic        [PW-1:0] mag_sum;

    // Sign-extend the operand and take its magnitude.
    always_comb begin
        op_ext = PW'(op);
        op_mag = op_ext[PW-1] ? PW'(-op_ext) : PW'(op_ext);
    end

    // One shifted copy of the magnitude for each set bit of the constant.
    for (genvar b = 0; b < MB; b++) begin : g_term
        if (((MAG >> b) & 1) != 0) begin : g_on
            assign term[b] = op_mag << b;
        end else begin : g_off
            assign term[b] = '0;
        end
    end

    // Sum the partial products and restore the sign of the product.
    always_comb begin
        mag_sum = '0;
        for (int b = 0; b < MB; b++) mag_sum = mag_sum + term[b];
        prod = (op[IW-1] ^ NEG) ? -$signed(mag_sum) : $signed(mag_sum);
    end

endmodule

// File: rtl/dfly_addnet.sv
// Radix-4 add/subtract network with one register stage.
// Forms the four branch sums (quarter-turn rotations done by swap and negate)
// and captures them only when in_valid is high; otherwise the stage holds.
// Assumes: SW >= DW+2, so a four-term sum cannot overflow.
module dfly_addnet #(
    parameter int DW = 5,
    parameter int SW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_re [4],
    input  logic signed [DW-1:0] x_im [4],
    output logic                 st_valid,
    output logic signed [SW-1:0] s_re [4],
    output logic signed [SW-1:0] s_im [4]
);
    logic signed [SW-1:0] er [4];
    logic signed [SW-1:0] ei [4];
    logic signed [SW-1:0] nr [4];
    logic signed [SW-1:0] ni [4];

    // Widen the inputs with sign extension.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            er[i] = SW'(x_re[i]);
            ei[i] = SW'(x_im[i]);
        end
    end

    // Branch sums: 0 -> plain sum, 1 -> a-jb-c+jd, 2 -> a-b+c-d, 3 -> a+jb-c-jd.
    always_comb begin
        nr[0] = er[0] + er[1] + er[2] + er[3];
        ni[0] = ei[0] + ei[1] + ei[2] + ei[3];
        nr[1] = er[0] + ei[1] - er[2] - ei[3];
        ni[1] = ei[0] - er[1] - ei[2] + er[3];
        nr[2] = er[0] - er[1] + er[2] - er[3];
        ni[2] = ei[0] - ei[1] + ei[2] - ei[3];
        nr[3] = er[0] - ei[1] - er[2] + ei[3];
        ni[3] = ei[0] + er[1] - ei[2] - er[3];
    end

    // Stage register: load on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            for (int i = 0; i < 4; i++) begin
                s_re[i] <= '0;
                s_im[i] <= '0;
            end
        end else begin
            st_valid <= in_valid;
            if (in_valid) begin
                for (int i = 0; i < 4; i++) begin
                    s_re[i] <= nr[i];
                    s_im[i] <= ni[i];
                end
            end
        end
    end

    p_stage_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> st_valid);
    p_stage_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !st_valid);
    p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(s_re[0]) && $stable(s_im[0]) && $stable(s_re[1]) &&
                       $stable(s_im[1]) && $stable(s_re[2]) && $stable(s_im[2]) &&
                       $stable(s_re[3]) && $stable(s_im[3])));

endmodule

// File: rtl/dfly_branch.sv
// One output branch: either a zero-angle delay register, or a constant complex
// rotation by W^EXP = C - jS built from four shift-add multipliers, followed by
// round-half-up rescaling by 2**TW and an output register.
// Assumes: OW is wide enough for |sum|*sqrt(2); a checker guards this.
module dfly_branch #(
    parameter int SW   = 7,
    parameter int OW   = 8,
    parameter int TW   = 10,
    parameter int NPTS = 256,
    parameter int EXP  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic signed [SW-1:0] p_in,
    input  logic signed [SW-1:0] t_in,
    output logic signed [OW-1:0] y_re,
    output logic signed [OW-1:0] y_im
);
    if ((EXP % NPTS) == 0) begin : g_delay
        // Zero angle: register the sum, matching the rotated branches' timing.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                y_re <= '0;
                y_im <= '0;
            end else if (ld) begin
                y_re <= OW'(p_in);
                y_im <= OW'(t_in);
            end
        end

        p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ld |=> (int'(y_re) == $past(int'(p_in)) && int'(y_im) == $past(int'(t_in))));

    end else begin : g_rotate
        localparam int C    = dfly_pkg::twiddle_cos_q(EXP, NPTS, TW);
        localparam int S    = dfly_pkg::twiddle_sin_q(EXP, NPTS, TW);
        localparam int PW   = SW + TW + 2;
        localparam int AW   = PW + 1;
        localparam int HALF = 1 << (TW - 1);

        logic signed [PW-1:0] pc, ts, tc, ps;
        logic signed [AW-1:0] acc_re, acc_im, rnd_re, rnd_im;

        dfly_cmul #(.IW(SW), .TW(TW), .COEF(C), .PW(PW)) u_pc (.op(p_in), .prod(pc));
        dfly_cmul #(.IW(SW), .TW(TW), .COEF(S), .PW(PW)) u_ts (.op(t_in), .prod(ts));
        dfly_cmul #(.IW(SW), .TW(TW), .COEF(C), .PW(PW)) u_tc (.op(t_in), .prod(tc));
        dfly_cmul #(.IW(SW), .TW(TW), .COEF(S), .PW(PW)) u_ps (.op(p_in), .prod(ps));

        // (P + jT)(C - jS) = (PC + TS) + j(TC - PS), then round half up.
        always_comb begin
            acc_re = AW'(pc) + AW'(ts);
            acc_im = AW'(tc) - AW'(ps);
            rnd_re = (acc_re + AW'(HALF)) >>> TW;
            rnd_im = (acc_im + AW'(HALF)) >>> TW;
        end

        // Output register for the rotated branch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                y_re <= '0;
                y_im <= '0;
            end else if (ld) begin
                y_re <= rnd_re[OW-1:0];
                y_im <= rnd_im[OW-1:0];
            end
        end

        p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ld |-> ((rnd_re[AW-1:OW-1] == '0 || rnd_re[AW-1:OW-1] == '1) &&
                    (rnd_im[AW-1:OW-1] == '0 || rnd_im[AW-1:OW-1] == '1)));
    end

endmodule

// File: rtl/dragonfly_r4_const.sv
// Fully parallel radix-4 DIF node with build-time twiddles.
// Four complex inputs per cycle, four complex outputs two cycles later.
// Branch m is rotated by W^(m*K mod NPTS); zero-angle branches are delays.
// Assumes: 0 <= K, NPTS a power of four, TW >= 1.
module dragonfly_r4_const #(
    parameter int DW   = 5,
    parameter int TW   = 10,
    parameter int NPTS = 256,
    parameter int K    = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   a_re,
    input  logic signed [DW-1:0]   a_im,
    input  logic signed [DW-1:0]   b_re,
    input  logic signed [DW-1:0]   b_im,
    input  logic signed [DW-1:0]   c_re,
    input  logic signed [DW-1:0]   c_im,
    input  logic signed [DW-1:0]   d_re,
    input  logic signed [DW-1:0]   d_im,
    output logic                   out_valid,
    output logic signed [DW+2:0]   y0_re,
    output logic signed [DW+2:0]   y0_im,
    output logic signed [DW+2:0]   y1_re,
    output logic signed [DW+2:0]   y1_im,
    output logic signed [DW+2:0]   y2_re,
    output logic signed [DW+2:0]   y2_im,
    output logic signed [DW+2:0]   y3_re,
    output logic signed [DW+2:0]   y3_im
);
    localparam int SW = DW + 2;
    localparam int OW = DW + 3;

    logic signed [DW-1:0] xr [4];
    logic signed [DW-1:0] xi [4];
    logic                 st_valid;
    logic signed [SW-1:0] s_re [4];
    logic signed [SW-1:0] s_im [4];
    logic signed [OW-1:0] br_re [dfly_pkg::BRANCHES];
    logic signed [OW-1:0] br_im [dfly_pkg::BRANCHES];

    assign xr[0] = a_re;  assign xi[0] = a_im;
    assign xr[1] = b_re;  assign xi[1] = b_im;
    assign xr[2] = c_re;  assign xi[2] = c_im;
    assign xr[3] = d_re;  assign xi[3] = d_im;

    dfly_addnet #(.DW(DW), .SW(SW)) u_add (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_re(xr), .x_im(xi),
        .st_valid(st_valid), .s_re(s_re), .s_im(s_im)
    );

    for (genvar m = 0; m < dfly_pkg::BRANCHES; m++) begin : g_br
        dfly_branch #(
            .SW(SW), .OW(OW), .TW(TW), .NPTS(NPTS),
            .EXP(dfly_pkg::twiddle_index(m, K, NPTS))
        ) u_br (
            .clk(clk), .rst_n(rst_n), .ld(st_valid),
            .p_in(s_re[m]), .t_in(s_im[m]),
            .y_re(br_re[m]), .y_im(br_im[m])
        );
    end

    assign y0_re = br_re[0];  assign y0_im = br_im[0];
    assign y1_re = br_re[1];  assign y1_im = br_im[1];
    assign y2_re = br_re[2];  assign y2_im = br_im[2];
    assign y3_re = br_re[3];  assign y3_im = br_im[3];

    // Output valid follows the stage valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= st_valid;
    end

    p_out_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> out_valid);
    p_out_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !out_valid);
    p_branch0_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 (int'(y0_re) ==
            $past(int'(a_re) + int'(b_re) + int'(c_re) + int'(d_re), 2) &&
            int'(y0_im) ==
            $past(int'(a_im) + int'(b_im) + int'(c_im) + int'(d_im), 2)));

endmodule

// File: tb/dragonfly_r4_const_test.sv
`timescale 1ns/1ps
module dragonfly_r4_const_test;
    localparam int DW = 5;
    localparam int OW = DW + 3;
    localparam int KA = 13;
    localparam int KB = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] x [8];
    logic va, vb;
    logic signed [OW-1:0] ya [8];
    logic signed [OW-1:0] yb [8];

    int tests = 0;
    int fails = 0;
    int st_in [8];
    int op_in [8];
    int drv_in [8];
    int nxt [8];
    bit st_v = 0, op_v = 0, drv_v = 0, held = 0;

    always #4 clk = ~clk;

    dragonfly_r4_const #(.DW(DW), .K(KA)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(x[0]), .a_im(x[1]), .b_re(x[2]), .b_im(x[3]),
        .c_re(x[4]), .c_im(x[5]), .d_re(x[6]), .d_im(x[7]),
        .out_valid(va),
        .y0_re(ya[0]), .y0_im(ya[1]), .y1_re(ya[2]), .y1_im(ya[3]),
        .y2_re(ya[4]), .y2_im(ya[5]), .y3_re(ya[6]), .y3_im(ya[7]));

    dragonfly_r4_const #(.DW(DW), .K(KB)) uut_h (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(x[0]), .a_im(x[1]), .b_re(x[2]), .b_im(x[3]),
        .c_re(x[4]), .c_im(x[5]), .d_re(x[6]), .d_im(x[7]),
        .out_valid(vb),
        .y0_re(yb[0]), .y0_im(yb[1]), .y1_re(yb[2]), .y1_im(yb[3]),
        .y2_re(yb[4]), .y2_im(yb[5]), .y3_re(yb[6]), .y3_im(yb[7]));

    function automatic int q_round(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // Reference for branch m of a node with index k (R1..R7).
    function automatic void ref_branch(input int k, input int m, input int s[8],
                                       output int re, output int im);
        int p, t, n, c, sn;
        real ang;
        case (m)
            0: begin p = s[0] + s[2] + s[4] + s[6]; t = s[1] + s[3] + s[5] + s[7]; end
            1: begin p = s[0] + s[3] - s[4] - s[7]; t = s[1] - s[2] - s[5] + s[6]; end
            2: begin p = s[0] - s[2] + s[4] - s[6]; t = s[1] - s[3] + s[5] - s[7]; end
            default: begin p = s[0] - s[3] - s[4] + s[7]; t = s[1] + s[2] - s[5] - s[6]; end
        endcase
        n = (m * k) % 256;
        if (m == 0 || n == 0) begin
            re = p; im = t;
        end else begin
            ang = 2.0 * 3.141592653589793 * real'(n) / 256.0;
            c  = q_round(1024.0 * $cos(ang));
            sn = q_round(1024.0 * $sin(ang));
            re = (p * c + t * sn + 512) >>> 10;
            im = (t * c - p * sn + 512) >>> 10;
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int ar, input int ai, input int er, input int ei);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual (%0d,%0d) expected (%0d,%0d)", tag, what, ar, ai, er, ei);
        end
    endtask

    task automatic compare_all();
        int er, ei;
        string tag;
        check(va == op_v && vb == op_v, "R8", "out_valid", int'(va), int'(vb), int'(op_v), int'(op_v));
        for (int m = 0; m < 4; m++) begin
            ref_branch(KA, m, op_in, er, ei);
            tag = (m == 0) ? "R1" : (m == 1) ? "R2 R5 R6" : (m == 2) ? "R3 R5 R6" : "R4 R5 R6";
            if (held) tag = {tag, " R9"};
            check(int'(ya[2*m]) == er && int'(ya[2*m+1]) == ei, tag,
                  $sformatf("K13 y%0d", m), int'(ya[2*m]), int'(ya[2*m+1]), er, ei);
            ref_branch(KB, m, op_in, er, ei);
            tag = (m == 2) ? "R7" : (m == 0) ? "R1" : "R2 R4 R5";
            check(int'(yb[2*m]) == er && int'(yb[2*m+1]) == ei, tag,
                  $sformatf("K128 y%0d", m), int'(yb[2*m]), int'(yb[2*m+1]), er, ei);
        end
    endtask

    // One cycle: mirror the clock edge in the model, check, then drive nxt.
    task automatic cycle(input bit v);
        @(negedge clk);
        held = !st_v && op_v;
        if (st_v) op_in = st_in;
        op_v = st_v;
        st_v = drv_v;
        if (drv_v) st_in = drv_in;
        compare_all();
        in_valid = v;
        for (int i = 0; i < 8; i++) x[i] = DW'(nxt[i]);
        drv_v = v;
        if (v) drv_in = nxt;
    endtask

    task automatic fill(input int val);
        for (int i = 0; i < 8; i++) nxt[i] = val;
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 8; i++) nxt[i] = int'($urandom_range(31, 0)) - 16;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual (timeout) expected (finish)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7103));
        for (int i = 0; i < 8; i++) begin
            x[i] = DW'(9 - i);
            st_in[i] = 0; op_in[i] = 0; drv_in[i] = 0; nxt[i] = 0;
        end
        // R10: reset dominates even with valid data presented.
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            check(ya[i] == '0 && yb[i] == '0, "R10", $sformatf("reset out%0d", i),
                  int'(ya[i]), int'(yb[i]), 0, 0);
        end
        check(!va && !vb, "R10", "reset valid", int'(va), int'(vb), 0, 0);
        in_valid = 1'b0;
        for (int i = 0; i < 8; i++) x[i] = '0;
        rst_n = 1'b1;

        // Directed corners: R11 extremes, impulse, alternating signs.
        fill(-16);  cycle(1);
        fill(15);   cycle(1);
        fill(0); nxt[0] = 15; cycle(1);
        fill(0); nxt[3] = -16; cycle(1);
        for (int i = 0; i < 8; i++) nxt[i] = (i % 2 == 0) ? 15 : -16;
        cycle(1);
        nxt = '{15, 15, -16, 15, -16, -16, 15, -16}; cycle(1);
        nxt = '{-16, 15, 15, 15, 15, -16, -16, -16}; cycle(1);
        // R9: garbage with valid low, outputs must hold.
        fill(7); cycle(0);
        fill(-9); cycle(0);
        fill(0); cycle(0);
        cycle(0);

        // Random bursts with idle gaps (R2..R9).
        for (int n = 0; n < 600; n++) begin
            fill_rand();
            cycle($urandom_range(3, 0) != 0);
        end
        fill(3);
        repeat (4) cycle(0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule